// File: doc/BRIEF.md
# Linear Chirp Frequency Sweep Generator

This block is the numeric core of a direct digital synthesizer. All of its logic runs on one fast system clock. A 32-bit phase accumulator adds the current tuning word on every clock edge. The output frequency is therefore the tuning word times the clock rate, divided by 2^32. The upper bits of the accumulator are sent out as a phase word, which a later amplitude stage can turn into a sine sample.

The tuning word can be held constant, which gives a single tone. It can also be ramped linearly by a separate frequency accumulator, which gives a chirp. In a ramp, a signed step is added to the running tuning word at a programmable interval. That interval is counted by a reloadable down-counter. The down-counter advances once every eight system clocks.

One update strobe captures the start word, the step, the interval and the mode. Software or a sequencer drives these inputs. After the strobe the block runs on its own until the next strobe arrives.

Top module: `chirp_sweep_gen`

## Requirements
- R1: While `rst` is high at a clock edge, the tuning word, the phase accumulator and the phase output go to zero and the mode becomes single tone.
- R2: An edge with `update_i` high loads `start_tw_i` into the tuning word. The same edge captures `mode_i`, `delta_tw_i` and `rate_i`, and restarts the interval counter and the divide-by-8 prescaler. The phase accumulator keeps its value.
- R3: With single-tone mode captured (`mode_i` = 0), the tuning word stays equal to the loaded start word until the next update.
- R4: On every edge the phase accumulator takes its old value plus the tuning word, modulo 2^32. `phase_o` shows the upper 14 bits of the accumulator value from one edge earlier.
- R5: With sweep mode captured (`mode_i` = 1) and a rate word r > 0, the tuning word m edges after the loading edge equals start + floor(m/(8·r))·delta, modulo 2^32.
- R6: A rate word of 1 steps the tuning word every 8 clocks. The first step lands on the 8th edge after the load.
- R7: A rate word of 0 in sweep mode produces no steps. The tuning word holds at the start word.
- R8: The tuning word wraps modulo 2^32 in both directions, with no saturation.
- R9: `delta_tw_i` is read as two's complement. A negative value lowers the tuning word by its magnitude at every step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| update_i | input | 1 | Strobe that loads a new profile |
| mode_i | input | 1 | 0 = single tone, 1 = linear sweep |
| start_tw_i | input | 32 | Start tuning word |
| delta_tw_i | input | 32 | Signed step added at each step |
| rate_i | input | 16 | Interval word, in units of 8 clocks |
| tuning_word_o | output | 32 | Current tuning word |
| phase_o | output | 14 | Upper phase bits, delayed one clock |

## Verification
The profile inputs are varied across several runs:
- Interval words 0 through 5 are each paired with small and large positive steps and with negative steps. A wrong period, a wrong first-step position or a misread sign each gives a different tuning-word trace.
- A tone profile with a non-zero step and interval shows that the ramp logic stays idle outside sweep mode.
- Start words placed just below 2^32 and just above zero drive the ramp across the wrap boundary in both directions.
- The phase word is tracked across all of these runs and across the reloads between them, so a reload that clears the phase accumulator, or a missing output delay, shows up.

// File: rtl/chirp_pkg.sv
package chirp_pkg;

    localparam int unsigned TW_W = 32;

    typedef enum logic {
        MODE_TONE  = 1'b0,
        MODE_SWEEP = 1'b1
    } sweep_mode_e;

    typedef struct packed {
        sweep_mode_e     mode;
        logic [TW_W-1:0] delta;
    } sweep_cfg_t;

    function automatic logic [TW_W-1:0] tw_advance(input logic [TW_W-1:0] tw,
                                                   input logic [TW_W-1:0] delta);
        return tw + delta;
    endfunction

endpackage

// File: rtl/chirp_ramp_timer.sv
module chirp_ramp_timer #(
    parameter int unsigned RATE_W   = 16,
    parameter int unsigned PRESCALE = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_i,
    input  logic [RATE_W-1:0] rate_i,
    output logic              step_o
);
    localparam int unsigned PS_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;

    logic [RATE_W-1:0] rate_q;
    logic [RATE_W-1:0] count_q;
    logic              tick;

    generate
        if (PRESCALE > 1) begin : g_prescale
            localparam logic [PS_W-1:0] PS_LAST = PS_W'(PRESCALE - 1);
            logic [PS_W-1:0] ps_q;

            always_ff @(posedge clk) begin
                if (rst || load_i) ps_q <= '0;
                else if (ps_q == PS_LAST) ps_q <= '0;
                else ps_q <= ps_q + 1'b1;
            end

            assign tick = (ps_q == PS_LAST);

            // R5: a step never lands on two adjacent clocks when prescaling
            p_step_gap_r5: assert property (@(posedge clk) disable iff (rst)
                step_o |=> !step_o);
        end else begin : g_no_prescale
            assign tick = 1'b1;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            rate_q  <= '0;
            count_q <= '0;
        end else if (load_i) begin
            rate_q  <= rate_i;
            count_q <= rate_i;
        end else if (tick && count_q != '0) begin
            if (count_q == RATE_W'(1)) count_q <= rate_q;
            else count_q <= count_q - 1'b1;
        end
    end

    assign step_o = tick && (count_q == RATE_W'(1)) && !load_i;

    // R7: a zero interval word never yields a step
    p_zero_rate_idle_r7: assert property (@(posedge clk) disable iff (rst)
        (rate_q == '0 && !load_i) |=> !step_o);

endmodule

// File: rtl/chirp_freq_acc.sv
module chirp_freq_acc
    import chirp_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            load_i,
    input  logic [TW_W-1:0] start_i,
    input  sweep_cfg_t      cfg_i,
    input  logic            step_i,
    output logic [TW_W-1:0] tw_o
);
    sweep_cfg_t      cfg_q;
    logic [TW_W-1:0] tw_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q.mode  <= MODE_TONE;
            cfg_q.delta <= '0;
            tw_q        <= '0;
        end else if (load_i) begin
            cfg_q <= cfg_i;
            tw_q  <= start_i;
        end else if (step_i && cfg_q.mode == MODE_SWEEP) begin
            tw_q <= tw_advance(tw_q, cfg_q.delta);
        end
    end

    assign tw_o = tw_q;

    // R2: the loading edge places the start word on the output
    p_load_start_r2: assert property (@(posedge clk) disable iff (rst)
        load_i |=> (tw_o == $past(start_i)));

    // R3: in tone mode the word only changes through a load
    p_tone_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (!load_i && cfg_q.mode == MODE_TONE) |=> $stable(tw_o));

endmodule

// File: rtl/chirp_phase_acc.sv
module chirp_phase_acc #(
    parameter int unsigned PHASE_W = 32,
    parameter int unsigned OUT_W   = 14
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [PHASE_W-1:0] tw_i,
    output logic [OUT_W-1:0]   phase_o
);
    localparam int unsigned LSB = PHASE_W - OUT_W;

    logic [PHASE_W-1:0] acc_q;
    logic [OUT_W-1:0]   out_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
            out_q <= '0;
        end else begin
            acc_q <= acc_q + tw_i;
            out_q <= acc_q[PHASE_W-1:LSB];
        end
    end

    assign phase_o = out_q;

    // R4: the accumulator advances by the word it saw on the previous clock
    p_phase_step_r4: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (acc_q == $past(acc_q) + $past(tw_i)));

    // R4: the output is the upper slice of the previous accumulator value
    p_phase_lag_r4: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (phase_o == $past(acc_q[PHASE_W-1:LSB])));

endmodule

// File: rtl/chirp_sweep_gen.sv
module chirp_sweep_gen
    import chirp_pkg::*;
#(
    parameter int unsigned RATE_W    = 16,
    parameter int unsigned PRESCALE  = 8,
    parameter int unsigned PHASE_OUT = 14
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 update_i,
    input  logic                 mode_i,
    input  logic [TW_W-1:0]      start_tw_i,
    input  logic [TW_W-1:0]      delta_tw_i,
    input  logic [RATE_W-1:0]    rate_i,
    output logic [TW_W-1:0]      tuning_word_o,
    output logic [PHASE_OUT-1:0] phase_o
);
    sweep_cfg_t      cfg_in;
    logic            step;
    logic [TW_W-1:0] tw;

    assign cfg_in.mode  = sweep_mode_e'(mode_i);
    assign cfg_in.delta = delta_tw_i;

    chirp_ramp_timer #(
        .RATE_W  (RATE_W),
        .PRESCALE(PRESCALE)
    ) u_timer (
        .clk   (clk),
        .rst   (rst),
        .load_i(update_i),
        .rate_i(rate_i),
        .step_o(step)
    );

    chirp_freq_acc u_freq (
        .clk    (clk),
        .rst    (rst),
        .load_i (update_i),
        .start_i(start_tw_i),
        .cfg_i  (cfg_in),
        .step_i (step),
        .tw_o   (tw)
    );

    chirp_phase_acc #(
        .PHASE_W(TW_W),
        .OUT_W  (PHASE_OUT)
    ) u_phase (
        .clk    (clk),
        .rst    (rst),
        .tw_i   (tw),
        .phase_o(phase_o)
    );

    assign tuning_word_o = tw;

    // R5: without a load or a step the tuning word keeps its value
    p_word_moves_on_step_r5: assert property (@(posedge clk) disable iff (rst)
        (!update_i && !step) |=> $stable(tuning_word_o));

    // R1: the edge after reset leaves the tuning word at zero
    p_reset_zero_r1: assert property (@(posedge clk)
        rst |=> (tuning_word_o == '0));

endmodule

// File: tb/tb_chirp_sweep_gen.sv
`timescale 1ns/1ps
module tb_chirp_sweep_gen;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        update_i = 1'b0;
    logic        mode_i = 1'b0;
    logic [31:0] start_tw_i = '0;
    logic [31:0] delta_tw_i = '0;
    logic [15:0] rate_i = '0;
    logic [31:0] tuning_word_o;
    logic [13:0] phase_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [31:0] exp_tw = '0;
    logic [31:0] ph = '0;
    logic [13:0] exp_po = '0;

    always #10 clk = ~clk;

    chirp_sweep_gen dut (
        .clk          (clk),
        .rst          (rst),
        .update_i     (update_i),
        .mode_i       (mode_i),
        .start_tw_i   (start_tw_i),
        .delta_tw_i   (delta_tw_i),
        .rate_i       (rate_i),
        .tuning_word_o(tuning_word_o),
        .phase_o      (phase_o)
    );

    task automatic check32(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s tuning word actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic check14(input string tag, input logic [13:0] act, input logic [13:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s phase actual %h expected %h", tag, act, exp);
        end
    endtask

    // one clock edge: advance the reference, then compare at the falling edge
    task automatic cycle(input logic [31:0] next_tw, input string tw_tag, input string ph_tag);
        @(posedge clk);
        exp_po = ph[31:18];
        ph     = ph + exp_tw;
        exp_tw = next_tw;
        @(negedge clk);
        check32(tw_tag, tuning_word_o, exp_tw);
        check14(ph_tag, phase_o, exp_po);
    endtask

    task automatic run_profile(input bit sweep, input logic [31:0] s, input logic [31:0] d,
                               input int r, input int n, input string tag);
        update_i   = 1'b1;
        mode_i     = sweep;
        start_tw_i = s;
        delta_tw_i = d;
        rate_i     = 16'(r);
        cycle(s, "R2", "R2");
        update_i   = 1'b0;
        delta_tw_i = 32'h5A5A_0001;
        rate_i     = 16'd9;
        for (int m = 1; m <= n; m++) begin
            logic [31:0] nxt;
            if (sweep && r > 0) nxt = s + 32'(m / (8 * r)) * d;
            else nxt = s;
            cycle(nxt, tag, "R4");
        end
    endtask

    initial begin
        logic [31:0] deltas [4];
        deltas[0] = 32'h0000_0001;
        deltas[1] = 32'h0123_4567;
        deltas[2] = 32'hFFFF_FFFD;
        deltas[3] = 32'hF800_0000;

        repeat (3) @(posedge clk);
        @(negedge clk);
        check32("R1", tuning_word_o, 32'h0);
        check14("R1", phase_o, 14'h0);
        rst = 1'b0;

        // R3: tone mode ignores a non-zero step and interval
        run_profile(1'b0, 32'h1000_0000, 32'h0000_0005, 3, 60, "R3");

        // R6: rate word 1, first step on the 8th edge
        run_profile(1'b1, 32'h0200_0000, 32'h0010_0000, 1, 7, "R6");
        cycle(32'h0210_0000, "R6", "R4");
        cycle(32'h0210_0000, "R6", "R4");

        // R5, R7, R9: interval words 0..5 against several steps
        for (int r = 0; r <= 5; r++) begin
            for (int k = 0; k < 4; k++) begin
                string tag;
                if (r == 0) tag = "R7";
                else if (deltas[k][31]) tag = "R9";
                else if (r == 1) tag = "R6";
                else tag = "R5";
                run_profile(1'b1, 32'h4000_0000 + 32'(k), deltas[k], r, 8 * r * 4 + 10, tag);
            end
        end

        // R8: wrap upward and downward
        run_profile(1'b1, 32'hFFFF_FF00, 32'h0000_0040, 1, 60, "R8");
        run_profile(1'b1, 32'h0000_0080, 32'hFFFF_FFC0, 1, 60, "R8");

        // back to tone after a sweep; the phase keeps running (R2)
        run_profile(1'b0, 32'h0000_1234, 32'h0000_0001, 1, 30, "R3");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(20 * 150000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule